// File: doc/BRIEF.md
# Loader Byte-Write Bus Bridge

This block sits between a hardware program loader and the memory and I/O interconnect of a small processor system. The loader hands it one byte at a time, with a virtual address and a valid strobe. The bridge turns each byte into one write transfer on a 32-bit AHB-Lite master port. It maps the virtual address to a physical one by clearing its top address bits. The write data follows its address phase by one cycle, as the protocol's pipelining requires. The byte is copied onto every lane, and the low address bits select the lane. A memory made of four byte-wide banks can therefore store a single byte.

The same block also owns the bus multiplexer in front of the interconnect. While the load-active input is high, the bridge takes the bus from the processor and holds the processor in reset. When loading ends, the bridge hands the bus back at the first clock edge where none of its own transfers is still outstanding. The bridge respects the slave's ready signal: an address or data phase waits until ready is high, and the loader is back-pressured in the meantime.

Top module: `ldr_ahb_bridge`

## Requirements
- R1: After reset with load_active low, the core owns the bus, req_ready is 0, core_hold is 0, and m_htrans repeats core_htrans.
- R2: A loader transfer drives m_haddr equal to the request address with bits [31:29] cleared and bits [28:0] unchanged.
- R3: In the cycle after a request is accepted (req_valid and req_ready high at a clock edge), m_htrans is NONSEQ (2'b10), m_hwrite is 1 and m_hsize is 3'b000 (byte).
- R4: In the cycle after an address phase completes (m_hready high at the edge), m_hwdata holds the request byte on all four byte lanes [7:0], [15:8], [23:16], [31:24].
- R5: While the loader owns the bus and no address phase is pending, m_htrans is IDLE (2'b00), m_hwrite is 0 and m_hwdata is 0 outside a data phase.
- R6: While m_hready is low, a pending address phase keeps m_htrans and m_haddr unchanged, a pending data phase keeps m_hwdata unchanged, and req_ready is 0 if an address phase is pending.
- R7: When the core owns the bus, m_htrans, m_haddr, m_hwrite, m_hsize and m_hwdata equal the core's signals, and core_hready equals m_hready. When the loader owns the bus, core_hready is 1.
- R8: After load_active falls, ownership returns to the core at the first clock edge at which no loader address phase is pending and no loader data phase is still waiting on m_hready.
- R9: core_hold is high whenever load_active is high or the loader still owns the bus.
- R10: Requests are accepted only when req_ready is high, and req_ready is high only when load_active is high and the loader owns the bus. A request while load_active is low starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| load_active | input | 1 | Loading in progress; requests the bus for the loader |
| req_valid | input | 1 | Loader byte-write request valid |
| req_vaddr | input | 32 | Virtual byte address of the request |
| req_byte | input | 8 | Byte to write |
| req_ready | output | 1 | Request accepted at this edge when valid |
| core_hold | output | 1 | Holds the processor in reset |
| core_htrans | input | 2 | Processor transfer type |
| core_haddr | input | 32 | Processor address |
| core_hwrite | input | 1 | Processor write flag |
| core_hsize | input | 3 | Processor transfer size |
| core_hwdata | input | 32 | Processor write data |
| core_hready | output | 1 | Ready returned to the processor |
| m_htrans | output | 2 | Transfer type to the interconnect |
| m_haddr | output | 32 | Address to the interconnect |
| m_hwrite | output | 1 | Write flag to the interconnect |
| m_hsize | output | 3 | Transfer size to the interconnect |
| m_hwdata | output | 32 | Write data to the interconnect |
| m_hready | input | 1 | Ready from the interconnect |

## Verification
Single byte writes go to addresses with all, none and some of the top three bits set, and to every lane offset. These show whether only bits [31:29] are cleared and whether the low bits pass through. A back-to-back pair shows that the second address overlaps the first byte's data phase, which confirms the one-cycle data lag. Slave ready is held low in the address phase and in the data phase to check what stays frozen and when the loader is refused. Handover is tried twice, with and without a data phase still waiting when loading ends. A core that keeps driving a distinct transfer shows exactly which cycle the multiplexer switches back.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } htrans_e;

  localparam logic [2:0] SIZE_BYTE = 3'b000;

  // number of byte lanes on a data bus of the given width
  function automatic int lane_count(input int data_w);
    return data_w / 8;
  endfunction
endpackage

// File: rtl/ldr_addr_map.sv
// Fixed virtual-to-physical map: the top CLEAR_BITS address bits are forced to zero.
module ldr_addr_map #(
  parameter int ADDR_W     = 32,
  parameter int CLEAR_BITS = 3
) (
  input  logic [ADDR_W-1:0] vaddr,
  output logic [ADDR_W-1:0] paddr
);
  localparam int KEEP_W = ADDR_W - CLEAR_BITS;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    if (i >= KEEP_W) begin : g_clr
      assign paddr[i] = 1'b0;
    end else begin : g_keep
      assign paddr[i] = vaddr[i];
    end
  end
endmodule

// File: rtl/ldr_xfer_engine.sv
// Two-stage write pipeline: address phase register, then data phase register.
module ldr_xfer_engine #(
  parameter int ADDR_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_paddr,
  input  logic [BYTE_W-1:0] req_byte,
  input  logic              bus_hready,
  output logic              req_ready,
  output logic              aph_valid,
  output logic [ADDR_W-1:0] aph_addr,
  output logic              dph_valid,
  output logic [BYTE_W-1:0] dph_byte,
  output logic              drain_busy
);
  logic [BYTE_W-1:0] aph_byte;
  logic              accept;

  assign req_ready  = enable & (~aph_valid | bus_hready);
  assign accept     = req_valid & req_ready;
  // a transfer remains in flight after this edge
  assign drain_busy = aph_valid | (dph_valid & ~bus_hready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aph_valid <= 1'b0;
      aph_addr  <= '0;
      aph_byte  <= '0;
      dph_valid <= 1'b0;
      dph_byte  <= '0;
    end else begin
      if (bus_hready) begin
        dph_valid <= aph_valid;
        if (aph_valid) dph_byte <= aph_byte;
      end
      if (accept) begin
        aph_valid <= 1'b1;
        aph_addr  <= req_paddr;
        aph_byte  <= req_byte;
      end else if (bus_hready) begin
        aph_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ldr_bus_owner.sv
// Tracks which master owns the interconnect.
module ldr_bus_owner (
  input  logic clk,
  input  logic rst_n,
  input  logic load_active,
  input  logic drain_busy,
  output logic own_loader
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own_loader <= 1'b0;
    else        own_loader <= load_active | drain_busy;
  end
endmodule

// File: rtl/ldr_bus_mux.sv
// Selects core or loader signals onto the interconnect; byte copied on each lane.
module ldr_bus_mux #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              own_loader,
  input  logic              aph_valid,
  input  logic [ADDR_W-1:0] aph_addr,
  input  logic              dph_valid,
  input  logic [7:0]        dph_byte,
  input  logic [1:0]        core_htrans,
  input  logic [ADDR_W-1:0] core_haddr,
  input  logic              core_hwrite,
  input  logic [2:0]        core_hsize,
  input  logic [DATA_W-1:0] core_hwdata,
  input  logic              m_hready,
  output logic              core_hready,
  output logic [1:0]        m_htrans,
  output logic [ADDR_W-1:0] m_haddr,
  output logic              m_hwrite,
  output logic [2:0]        m_hsize,
  output logic [DATA_W-1:0] m_hwdata
);
  import ldr_pkg::*;
  localparam int LANES = lane_count(DATA_W);

  logic [DATA_W-1:0] ldr_wdata;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign ldr_wdata[l*8 +: 8] = dph_valid ? dph_byte : 8'h00;
  end

  always_comb begin
    if (own_loader) begin
      m_htrans    = aph_valid ? TR_NONSEQ : TR_IDLE;
      m_haddr     = aph_addr;
      m_hwrite    = aph_valid;
      m_hsize     = SIZE_BYTE;
      m_hwdata    = ldr_wdata;
      core_hready = 1'b1;
    end else begin
      m_htrans    = core_htrans;
      m_haddr     = core_haddr;
      m_hwrite    = core_hwrite;
      m_hsize     = core_hsize;
      m_hwdata    = core_hwdata;
      core_hready = m_hready;
    end
  end
endmodule

// File: rtl/ldr_ahb_bridge.sv
module ldr_ahb_bridge #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int CLEAR_BITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_active,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [7:0]        req_byte,
  output logic              req_ready,
  output logic              core_hold,
  input  logic [1:0]        core_htrans,
  input  logic [ADDR_W-1:0] core_haddr,
  input  logic              core_hwrite,
  input  logic [2:0]        core_hsize,
  input  logic [DATA_W-1:0] core_hwdata,
  output logic              core_hready,
  output logic [1:0]        m_htrans,
  output logic [ADDR_W-1:0] m_haddr,
  output logic              m_hwrite,
  output logic [2:0]        m_hsize,
  output logic [DATA_W-1:0] m_hwdata,
  input  logic              m_hready
);
  logic [ADDR_W-1:0] req_paddr;
  logic              own_loader;
  logic              eng_enable;
  logic              aph_valid;
  logic [ADDR_W-1:0] aph_addr;
  logic              dph_valid;
  logic [7:0]        dph_byte;
  logic              drain_busy;

  assign eng_enable = own_loader & load_active;
  assign core_hold  = load_active | own_loader;

  ldr_addr_map #(.ADDR_W(ADDR_W), .CLEAR_BITS(CLEAR_BITS)) u_map (
    .vaddr (req_vaddr),
    .paddr (req_paddr)
  );

  ldr_xfer_engine #(.ADDR_W(ADDR_W), .BYTE_W(8)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (eng_enable),
    .req_valid  (req_valid),
    .req_paddr  (req_paddr),
    .req_byte   (req_byte),
    .bus_hready (m_hready),
    .req_ready  (req_ready),
    .aph_valid  (aph_valid),
    .aph_addr   (aph_addr),
    .dph_valid  (dph_valid),
    .dph_byte   (dph_byte),
    .drain_busy (drain_busy)
  );

  ldr_bus_owner u_own (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_active (load_active),
    .drain_busy  (drain_busy),
    .own_loader  (own_loader)
  );

  ldr_bus_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .own_loader  (own_loader),
    .aph_valid   (aph_valid),
    .aph_addr    (aph_addr),
    .dph_valid   (dph_valid),
    .dph_byte    (dph_byte),
    .core_htrans (core_htrans),
    .core_haddr  (core_haddr),
    .core_hwrite (core_hwrite),
    .core_hsize  (core_hsize),
    .core_hwdata (core_hwdata),
    .m_hready    (m_hready),
    .core_hready (core_hready),
    .m_htrans    (m_htrans),
    .m_haddr     (m_haddr),
    .m_hwrite    (m_hwrite),
    .m_hsize     (m_hsize),
    .m_hwdata    (m_hwdata)
  );
endmodule

// File: rtl/ldr_ahb_bridge_chk.sv
module ldr_ahb_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        load_active,
  input logic        own_loader,
  input logic        req_ready,
  input logic        core_hold,
  input logic [1:0]  m_htrans,
  input logic [31:0] m_haddr,
  input logic        m_hwrite,
  input logic [2:0]  m_hsize,
  input logic [31:0] m_hwdata,
  input logic        m_hready
);
  AST_WRITE_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (own_loader && m_htrans == 2'b10) |-> (m_hwrite && m_hsize == 3'b000)); // R3
  AST_PHYS_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (own_loader && m_htrans == 2'b10) |-> (m_haddr[31:29] == 3'b000)); // R2
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (own_loader && m_htrans == 2'b10 && !m_hready) |=> (m_htrans == 2'b10 && $stable(m_haddr))); // R6
  AST_DATA_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (own_loader && m_htrans == 2'b10 && m_hready) |=>
      (own_loader && m_hwdata[31:24] == m_hwdata[7:0] && m_hwdata[23:16] == m_hwdata[7:0]
       && m_hwdata[15:8] == m_hwdata[7:0])); // R4
  AST_CORE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    own_loader |-> core_hold); // R9
  AST_READY_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (own_loader && load_active)); // R10
endmodule

bind ldr_ahb_bridge ldr_ahb_bridge_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_active (load_active),
  .own_loader  (own_loader),
  .req_ready   (req_ready),
  .core_hold   (core_hold),
  .m_htrans    (m_htrans),
  .m_haddr     (m_haddr),
  .m_hwrite    (m_hwrite),
  .m_hsize     (m_hsize),
  .m_hwdata    (m_hwdata),
  .m_hready    (m_hready)
);

// File: tb/sim_ldr_ahb_bridge.sv
module sim_ldr_ahb_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_active = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [7:0]  req_byte = '0;
  logic        req_ready, core_hold, core_hready;
  logic [1:0]  core_htrans = 2'b00;
  logic [31:0] core_haddr = '0;
  logic        core_hwrite = 1'b0;
  logic [2:0]  core_hsize = 3'b010;
  logic [31:0] core_hwdata = '0;
  logic [1:0]  m_htrans;
  logic [31:0] m_haddr;
  logic        m_hwrite;
  logic [2:0]  m_hsize;
  logic [31:0] m_hwdata;
  logic        m_hready = 1'b1;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  ldr_ahb_bridge u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] phys(input logic [31:0] v);
    return {3'b000, v[28:0]};
  endfunction

  task automatic t_reset();
    chk("R1 htrans", {30'd0, m_htrans}, {30'd0, core_htrans});
    chk("R1 req_ready", {31'd0, req_ready}, 32'd0);
    chk("R1 core_hold", {31'd0, core_hold}, 32'd0);
  endtask

  task automatic t_core_pass();
    core_htrans = 2'b10; core_haddr = 32'hBFC0_0010; core_hwrite = 1'b1;
    core_hsize = 3'b010; core_hwdata = 32'hDEAD_BEEF; m_hready = 1'b0;
    #1;
    chk("R7 core haddr", m_haddr, 32'hBFC0_0010);
    chk("R7 core hwdata", m_hwdata, 32'hDEAD_BEEF);
    chk("R7 core hsize", {29'd0, m_hsize}, 32'd2);
    chk("R7 core hready low", {31'd0, core_hready}, 32'd0);
    m_hready = 1'b1; #1;
    chk("R7 core hready high", {31'd0, core_hready}, 32'd1);
    step();
  endtask

  task automatic t_ignore();
    req_valid = 1'b1; req_vaddr = 32'h8000_0004; req_byte = 8'h5A;
    step(); step();
    chk("R10 ready while inactive", {31'd0, req_ready}, 32'd0);
    chk("R10 no transfer, core addr", m_haddr, 32'hBFC0_0010);
    req_valid = 1'b0;
    step();
  endtask

  task automatic t_enter();
    load_active = 1'b1; #1;
    chk("R9 hold on load_active", {31'd0, core_hold}, 32'd1);
    step();
    chk("R5 idle on takeover", {30'd0, m_htrans}, 32'd0);
    chk("R5 hwrite idle", {31'd0, m_hwrite}, 32'd0);
    chk("R5 hwdata idle", m_hwdata, 32'd0);
    chk("R7 core_hready while loader owns", {31'd0, core_hready}, 32'd1);
    chk("R10 ready when owned", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic t_write(input logic [31:0] va, input logic [7:0] b);
    req_valid = 1'b1; req_vaddr = va; req_byte = b;
    step();
    req_valid = 1'b0;
    chk("R3 htrans NONSEQ", {30'd0, m_htrans}, 32'd2);
    chk("R3 hwrite", {31'd0, m_hwrite}, 32'd1);
    chk("R3 hsize byte", {29'd0, m_hsize}, 32'd0);
    chk("R2 phys addr", m_haddr, phys(va));
    step();
    chk("R4 replicated data", m_hwdata, {4{b}});
    chk("R5 idle after", {30'd0, m_htrans}, 32'd0);
    step();
    chk("R5 hwdata cleared", m_hwdata, 32'd0);
  endtask

  task automatic t_b2b();
    req_valid = 1'b1; req_vaddr = 32'hA000_0100; req_byte = 8'h11;
    step();
    req_vaddr = 32'hC000_0101; req_byte = 8'h22;
    step();
    req_valid = 1'b0;
    chk("R2 second addr", m_haddr, 32'h0000_0101);
    chk("R4 first data overlaps", m_hwdata, 32'h1111_1111);
    step();
    chk("R4 second data", m_hwdata, 32'h2222_2222);
    step();
  endtask

  task automatic t_stall();
    req_valid = 1'b1; req_vaddr = 32'hE000_0202; req_byte = 8'h3C;
    step();
    req_valid = 1'b0; m_hready = 1'b0;
    #1;
    chk("R6 ready low in stall", {31'd0, req_ready}, 32'd0);
    step(); step();
    chk("R6 htrans held", {30'd0, m_htrans}, 32'd2);
    chk("R6 haddr held", m_haddr, 32'h0000_0202);
    chk("R6 no data yet", m_hwdata, 32'd0);
    m_hready = 1'b1;
    step();
    chk("R4 data after stall", m_hwdata, 32'h3C3C_3C3C);
    m_hready = 1'b0;
    step(); step();
    chk("R6 data held", m_hwdata, 32'h3C3C_3C3C);
    m_hready = 1'b1;
    step();
    chk("R5 idle after stall", {30'd0, m_htrans}, 32'd0);
  endtask

  task automatic t_handover_wait();
    core_htrans = 2'b10; core_haddr = 32'h1234_5678;
    req_valid = 1'b1; req_vaddr = 32'h9FC0_0003; req_byte = 8'hA5;
    step();
    req_valid = 1'b0;
    step();
    m_hready = 1'b0; load_active = 1'b0;
    step();
    chk("R8 loader keeps bus", {31'd0, m_haddr == 32'h1234_5678}, 32'd0);
    chk("R9 hold while draining", {31'd0, core_hold}, 32'd1);
    chk("R6 data during drain", m_hwdata, 32'hA5A5_A5A5);
    m_hready = 1'b1;
    step();
    chk("R8 core back haddr", m_haddr, 32'h1234_5678);
    chk("R8 core back htrans", {30'd0, m_htrans}, 32'd2);
    chk("R9 hold released", {31'd0, core_hold}, 32'd0);
  endtask

  task automatic t_handover_quick();
    load_active = 1'b1;
    step();
    chk("R7 loader owns", {30'd0, m_htrans}, 32'd0);
    load_active = 1'b0;
    step();
    chk("R8 immediate return", m_haddr, 32'h1234_5678);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_core_pass();
    t_ignore();
    core_htrans = 2'b00;
    t_enter();
    t_write(32'hBFC0_0003, 8'hC3);
    t_write(32'hFFFF_FFFF, 8'h81);
    t_write(32'h0000_0002, 8'h7E);
    t_write(32'h2000_0001, 8'h00);
    t_b2b();
    t_stall();
    t_handover_wait();
    t_handover_quick();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule